// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement Selector

This block keeps approximate recency for every set of a four-way set-associative cache and names the way that should be replaced in a queried set. Each set has three tree bits. A root bit records which half of the set was touched last: ways 0/1 or ways 2/3. Each half has one more bit that records which of its two ways was touched last. The block stores no tags and no data. The cache controller pulses an access strobe with the set index and the way number on every hit and on every fill, and it reads the victim for any set through a separate query index.

The victim always comes from the half that was used less recently, and from the older way inside that half. This costs three bits per set instead of a full ordering. The price is that the chosen way is sometimes not the truly oldest way.

Top module: `plru4_sel`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears all three bits of every set to 0, so every set reports victim way 0 and state 3'b000.
- R2: state_o bit 0 is the root bit. An access to way 0 or way 1 sets it to 1, and an access to way 2 or way 3 clears it to 0.
- R3: state_o bit 1 is the low-half bit, set to 1 by an access to way 0 and cleared by an access to way 1. state_o bit 2 is the high-half bit, set to 1 by an access to way 2 and cleared by an access to way 3.
- R4: An access leaves the bit of the half it did not touch unchanged.
- R5: When the root bit is 1, the victim is way 3 if the high-half bit is 1 and way 2 if it is 0.
- R6: When the root bit is 0, the victim is way 1 if the low-half bit is 1 and way 0 if it is 0.
- R7: State changes only on a rising clock edge with acc_valid_i high. With the strobe low, changes on acc_set_i and acc_way_i have no effect.
- R8: An access changes only the set named by acc_set_i. All other sets keep their bits.
- R9: victim_way_o and state_o follow query_set_i combinationally. After an access, the way just accessed is never the victim of its set.
- R10: The victim is approximate. After accesses to ways 0, 1, 2, 3, 0 in that order in one set, the victim is way 2, although way 1 is the least recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe (hit or fill) |
| acc_set_i | input | IDX_W | Set index of the access |
| acc_way_i | input | 2 | Way that was accessed |
| query_set_i | input | IDX_W | Set whose victim is reported |
| victim_way_o | output | 2 | Replacement way for the queried set |
| state_o | output | 3 | Tree bits of the queried set {high, low, root} |

## Verification
An access is registered at the rising edge at which the strobe is high. Its effect on victim_way_o and state_o for that set is therefore visible in the same cycle, right after that edge, and never before it. A change of query_set_i moves both outputs with no clock at all. The bench drives every input on the falling edge and samples one nanosecond later. For an access, this places the sample one half period after the edge that stored it. For a query, it places the sample after the combinational settle and before the next rising edge.

// File: rtl/plru4_pkg.sv
package plru4_pkg;
  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS);

  // bit 2: way 2 newer than way 3; bit 1: way 0 newer than way 1; bit 0: half 0/1 newer
  typedef struct packed {
    logic hi_w2_newer;
    logic lo_w0_newer;
    logic lo_half_newer;
  } tree_t;

  localparam int unsigned TREE_W = $bits(tree_t);
endpackage

// File: rtl/plru4_update.sv
module plru4_update
  import plru4_pkg::*;
(
  input  tree_t             cur_i,
  input  logic [WAY_W-1:0]  way_i,
  output tree_t             nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    nxt_o.lo_half_newer = ~way_i[1];
    if (way_i[1]) nxt_o.hi_w2_newer = ~way_i[0];
    else          nxt_o.lo_w0_newer = ~way_i[0];
  end
endmodule

// File: rtl/plru4_victim.sv
module plru4_victim
  import plru4_pkg::*;
(
  input  tree_t             tree_i,
  output logic [WAY_W-1:0]  victim_o
);
  always_comb begin
    if (tree_i.lo_half_newer) victim_o = tree_i.hi_w2_newer ? 2'd3 : 2'd2;
    else                      victim_o = tree_i.lo_w0_newer ? 2'd1 : 2'd0;
  end

  // victim half is opposite the more recent half
  always_comb begin
    a_victim_half_r5: assert (victim_o[1] == tree_i.lo_half_newer);
  end
endmodule

// File: rtl/plru4_bank.sv
module plru4_bank
  import plru4_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned IDX_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_set_i,
  input  tree_t             wr_tree_i,
  input  logic [IDX_W-1:0]  rd_a_set_i,
  output tree_t             rd_a_o,
  input  logic [IDX_W-1:0]  rd_b_set_i,
  output tree_t             rd_b_o
);
  tree_t [NUM_SETS-1:0] state_q;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   state_q[g] <= '0;
      else if (wr_en_i && wr_set_i == IDX_W'(g))     state_q[g] <= wr_tree_i;
    end
  end

  assign rd_a_o = state_q[rd_a_set_i];
  assign rd_b_o = state_q[rd_b_set_i];

  p_idle_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(state_q));

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_clear_r1: assert (state_q == '0);
  end
endmodule

// File: rtl/plru4_sel.sv
module plru4_sel
  import plru4_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned IDX_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [IDX_W-1:0]  acc_set_i,
  input  logic [1:0]        acc_way_i,
  input  logic [IDX_W-1:0]  query_set_i,
  output logic [1:0]        victim_way_o,
  output logic [2:0]        state_o
);
  tree_t acc_cur, acc_nxt, qry_cur;

  plru4_bank #(.NUM_SETS(NUM_SETS)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (acc_valid_i),
    .wr_set_i   (acc_set_i),
    .wr_tree_i  (acc_nxt),
    .rd_a_set_i (acc_set_i),
    .rd_a_o     (acc_cur),
    .rd_b_set_i (query_set_i),
    .rd_b_o     (qry_cur)
  );

  plru4_update i_update (
    .cur_i (acc_cur),
    .way_i (acc_way_i),
    .nxt_o (acc_nxt)
  );

  plru4_victim i_victim (
    .tree_i   (qry_cur),
    .victim_o (victim_way_o)
  );

  assign state_o = qry_cur;

  p_root_upd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && query_set_i == acc_set_i) |=>
      ($stable(query_set_i) -> state_o[0] == !$past(acc_way_i[1])));

  p_other_half_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && query_set_i == acc_set_i) |=>
      ($stable(query_set_i) ->
        ($past(acc_way_i[1]) ? state_o[1] == $past(state_o[1])
                             : state_o[2] == $past(state_o[2]))));

  p_not_mru_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && query_set_i == acc_set_i) |=>
      ($stable(query_set_i) -> victim_way_o != $past(acc_way_i)));

  p_other_set_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && query_set_i != acc_set_i) |=>
      ($stable(query_set_i) -> $stable(state_o)));
endmodule

// File: tb/test_plru4_sel.sv
`timescale 1ns/1ps
module test_plru4_sel;
  localparam int unsigned NUM_SETS = 16;
  localparam int unsigned IDX_W    = $clog2(NUM_SETS);

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             acc_valid_i;
  logic [IDX_W-1:0] acc_set_i;
  logic [1:0]       acc_way_i;
  logic [IDX_W-1:0] query_set_i;
  logic [1:0]       victim_way_o;
  logic [2:0]       state_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  plru4_sel #(.NUM_SETS(NUM_SETS)) i_plru4_sel (.*);

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic access(input int s, input int w);
    @(negedge clk_i);
    acc_valid_i = 1'b1;
    acc_set_i   = IDX_W'(s);
    acc_way_i   = 2'(w);
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    #1;
  endtask

  task automatic look(input int s, output logic [2:0] st, output logic [1:0] vic);
    query_set_i = IDX_W'(s);
    #1;
    st  = state_o;
    vic = victim_way_o;
  endtask

  task automatic t_reset();
    logic [2:0] st; logic [1:0] v;
    for (int s = 0; s < NUM_SETS; s += 5) begin
      look(s, st, v);
      chk("R1 state", st, 3'b000);
      chk("R1 victim", {1'b0, v}, 3'd0);
    end
  endtask

  // all 8 tree states reached on sets 8..15
  task automatic t_all_states();
    logic [2:0] st; logic [1:0] v;
    for (int c = 0; c < 8; c++) begin
      int s = 8 + c;
      bit root = c[0], lo = c[1], hi = c[2];
      int wlo = lo ? 0 : 1;
      int whi = hi ? 2 : 3;
      if (root) begin access(s, whi); access(s, wlo); end
      else      begin access(s, wlo); access(s, whi); end
      look(s, st, v);
      chk("R2 root bit", {2'b0, st[0]}, {2'b0, root});
      chk("R3 half bits", {1'b0, st[2:1]}, {1'b0, hi, lo});
      if (root) chk("R5 victim", {1'b0, v}, {1'b0, hi ? 2'd3 : 2'd2});
      else      chk("R6 victim", {1'b0, v}, {1'b0, lo ? 2'd1 : 2'd0});
    end
  endtask

  task automatic t_other_half();
    logic [2:0] st; logic [1:0] v;
    access(1, 2);             // hi=1 root=0
    access(1, 1);             // lo=0 root=1, hi must stay 1
    look(1, st, v);
    chk("R4 high half kept", st, 3'b101);
    access(1, 0);             // lo=1 root=1
    access(1, 3);             // hi=0 root=0, lo must stay 1
    look(1, st, v);
    chk("R4 low half kept", st, 3'b010);
  endtask

  task automatic t_idle();
    logic [2:0] st; logic [1:0] v;
    query_set_i = IDX_W'(2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      acc_valid_i = 1'b0;
      acc_set_i   = IDX_W'(2);
      acc_way_i   = 2'(i);
    end
    @(negedge clk_i);
    look(2, st, v);
    chk("R7 no strobe no change", st, 3'b000);
  endtask

  task automatic t_isolation();
    logic [2:0] st; logic [1:0] v;
    access(3, 0);
    look(4, st, v);
    chk("R8 neighbour set", st, 3'b000);
    look(2, st, v);
    chk("R8 lower set", st, 3'b000);
    look(3, st, v);
    chk("R8 target set", st, 3'b011);
  endtask

  task automatic t_not_mru();
    logic [2:0] st; logic [1:0] v;
    for (int w = 0; w < 4; w++) begin
      access(5, w);
      look(5, st, v);
      checks++;
      if (v == 2'(w)) begin
        errors++;
        $display("FAIL R9: actual victim=%0d expected not %0d", v, w);
      end
    end
    look(6, st, v);
    chk("R9 query switch", {1'b0, v}, 3'd0);
    look(5, st, v);
    chk("R9 query back", {1'b0, v}, 3'd0);   // after 0..3: root=0 lo=0
  endtask

  task automatic t_approx();
    logic [2:0] st; logic [1:0] v;
    access(7, 0); access(7, 1); access(7, 2); access(7, 3); access(7, 0);
    look(7, st, v);
    chk("R10 approximate victim", {1'b0, v}, 3'd2);
  endtask

  initial begin
    rst_ni = 1'b0; acc_valid_i = 1'b0; acc_set_i = '0; acc_way_i = '0; query_set_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_all_states();
    t_other_half();
    t_idle();
    t_isolation();
    t_not_mru();
    t_approx();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule